// File: doc/BRIEF.md
# Processor Presence Bitmap

This block keeps one presence bit for each of up to 256 processors and shows them to software as a 32-byte, read-only status window. The window sits at I/O base 0xAF00 on a simple byte bus with an address, a read strobe and a write strobe. Bit k of window byte i stands for processor 8·i + k.

A separate event port adds or removes one processor at a time, by index. Each accepted event also produces a one-cycle set pulse on the processor-change bit of the first general-purpose-event status byte. The event-status register that owns that bit takes the pulse and handles enabling and interrupt delivery.

While reset is held, the bitmap is filled from a boot-processor count. Processors 0 through count−1 are marked present and every other processor is marked absent.

Top module: `cpu_hotadd_bitmap`

## Requirements
- R1: While rstN is low, bit k of window byte i becomes 1 exactly when 8·i + k is less than bootCount. A count of 8 or more remaining processors fills a byte with 0xFF, and a count of 0 or less clears it. rdData and gpeSetMask reset to 0x00.
- R2: A cycle with busRd high, busWr low and busAddr in 0xAF00..0xAF1F loads rdData at that clock edge with window byte (busAddr − 0xAF00). rdData holds its value until the next read.
- R3: A read at an address outside 0xAF00..0xAF1F loads rdData with 0x00.
- R4: An add event (evtValid high, evtAdd = 1) with evtIndex n < 256 sets bit (n mod 8) of byte (n / 8). The change shows from the next cycle, and no other bit changes.
- R5: A remove event (evtValid high, evtAdd = 0) with evtIndex n < 256 clears bit (n mod 8) of byte (n / 8). No other bit changes.
- R6: Each in-range add or remove event drives gpeSetMask to 0x04 (bit 2, the processor-change bit) for exactly the next cycle. In every other cycle gpeSetMask is 0x00.
- R7: Bus write cycles (busWr high) never change the bitmap and never start a read.
- R8: An event with evtIndex of 256 or more changes no bit, including the bit its low index bits would select, and produces no pulse on gpeSetMask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; the bitmap is filled from bootCount while low |
| bootCount | input | 9 | Number of processors present at boot (0..256) |
| evtValid | input | 1 | Processor add/remove event strobe |
| evtAdd | input | 1 | 1 = add processor, 0 = remove processor |
| evtIndex | input | 9 | Processor index; values of 256 and up are ignored |
| busAddr | input | 16 | Byte bus address |
| busRd | input | 1 | Byte bus read strobe |
| busWr | input | 1 | Byte bus write strobe (accepted and discarded) |
| rdData | output | 8 | Read data, registered one cycle after the read strobe |
| gpeSetMask | output | 8 | One-cycle set pulse for the first event-status byte (0x04 on a processor change) |

## Verification
The reset fill is tried with boot counts of 0, 8, 11, 13 and 256. Together these separate a full byte, an empty byte, a partial byte and the whole-window fill at both ends of the range. A table of adds, removes and bus writes then reaches the first, a middle and the last byte. It sets bits that are already set, clears bits inside a partial boot byte, and places the highest and lowest bit of one byte side by side, so a wrong byte select or a wrong bit mask shows up as a wrong byte value. Indices 256 and 263 alias onto existing bits through their low bits, so a missing range check changes a byte that is read back. Reads just below and just above the window tell a wrong bound on the address decode from a correct one.

// File: rtl/cpu_hotadd_pkg.sv
package cpu_hotadd_pkg;

  // Bit position of the processor-change flag in the first event-status byte
  localparam int CPU_EVT_BIT = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic setEn;   // add event accepted this cycle
    logic clrEn;   // remove event accepted this cycle
    logic rdEn;    // bus read accepted this cycle
    logic rdHit;   // accepted read falls inside the window
  } bmpStrobe_t;

  // Boot value of one status byte given the total boot processor count
  function automatic logic [7:0] fillByte(int count, int byteIdx);
    int remaining;
    logic [7:0] value;
    remaining = count - 8 * byteIdx;
    if (remaining >= 8) begin
      value = 8'hFF;
    end else if (remaining <= 0) begin
      value = 8'h00;
    end else begin
      value = 8'((1 << remaining) - 1);
    end
    return value;
  endfunction

endpackage

// File: rtl/cpu_hotadd_ctrl.sv
module cpu_hotadd_ctrl
  import cpu_hotadd_pkg::*;
#(
  parameter int MAX_CPUS = 256,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hAF00,
  parameter int IDX_W = 9,
  parameter int SEL_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtValid,
  input  logic              evtAdd,
  input  logic [IDX_W-1:0]  evtIndex,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  output bmpStrobe_t        strb,
  output logic [SEL_W-1:0]  evtByte,
  output logic [7:0]        evtBitMask,
  output logic [SEL_W-1:0]  rdByte,
  output logic [7:0]        gpeSetMask
);

  localparam int NUM_BYTES = MAX_CPUS / 8;
  localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(MAX_CPUS);
  localparam logic [ADDR_W-1:0] WIN_LEN = ADDR_W'(NUM_BYTES);
  localparam logic [7:0] EVT_MASK = 8'(1 << CPU_EVT_BIT);

  logic              idxInRange;
  logic [ADDR_W-1:0] winOffset;
  logic              inWindow;

  // Event decode: index splits into byte select and bit position
  always_comb begin
    idxInRange = (evtIndex < MAX_IDX);
    evtByte    = evtIndex[SEL_W+2:3];
    evtBitMask = 8'(1 << evtIndex[2:0]);
  end

  // Address decode: one unsigned compare covers both window bounds
  always_comb begin
    winOffset = busAddr - BASE_ADDR;
    inWindow  = (winOffset < WIN_LEN);
    rdByte    = winOffset[SEL_W-1:0];
  end

  always_comb begin
    strb.setEn = evtValid && idxInRange && evtAdd;
    strb.clrEn = evtValid && idxInRange && !evtAdd;
    strb.rdEn  = busRd && !busWr;
    strb.rdHit = inWindow;
  end

  // Registered one-cycle set pulse toward the event-status register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gpeSetMask <= 8'h00;
    end else if (strb.setEn || strb.clrEn) begin
      gpeSetMask <= EVT_MASK;
    end else begin
      gpeSetMask <= 8'h00;
    end
  end

endmodule

// File: rtl/cpu_hotadd_data.sv
module cpu_hotadd_data
  import cpu_hotadd_pkg::*;
#(
  parameter int NUM_BYTES = 32,
  parameter int CNT_W = 9,
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] bootCount,
  input  bmpStrobe_t       strb,
  input  logic [SEL_W-1:0] evtByte,
  input  logic [7:0]       evtBitMask,
  input  logic [SEL_W-1:0] rdByte,
  output logic [7:0]       rdData
);

  logic [NUM_BYTES-1:0][7:0] statusBytes;

  // One register byte per group of eight processors
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    logic byteSel;
    assign byteSel = (evtByte == SEL_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        statusBytes[g] <= fillByte(int'(bootCount), g);
      end else if (strb.setEn && byteSel) begin
        statusBytes[g] <= statusBytes[g] | evtBitMask;
      end else if (strb.clrEn && byteSel) begin
        statusBytes[g] <= statusBytes[g] & ~evtBitMask;
      end
    end
  end

  // Registered read port; outside the window returns zero
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= 8'h00;
    end else if (strb.rdEn) begin
      rdData <= strb.rdHit ? statusBytes[rdByte] : 8'h00;
    end
  end

endmodule

// File: rtl/cpu_hotadd_bitmap.sv
module cpu_hotadd_bitmap
  import cpu_hotadd_pkg::*;
#(
  parameter int MAX_CPUS = 256,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hAF00
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [$clog2(MAX_CPUS+1)-1:0]  bootCount,
  input  logic                           evtValid,
  input  logic                           evtAdd,
  input  logic [$clog2(MAX_CPUS):0]      evtIndex,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic                           busRd,
  input  logic                           busWr,
  output logic [7:0]                     rdData,
  output logic [7:0]                     gpeSetMask
);

  localparam int NUM_BYTES = MAX_CPUS / 8;
  localparam int SEL_W = $clog2(NUM_BYTES);
  localparam int IDX_W = $clog2(MAX_CPUS) + 1;
  localparam int CNT_W = $clog2(MAX_CPUS + 1);

  bmpStrobe_t       strb;
  logic [SEL_W-1:0] evtByte;
  logic [7:0]       evtBitMask;
  logic [SEL_W-1:0] rdByte;

  cpu_hotadd_ctrl #(
    .MAX_CPUS (MAX_CPUS),
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR),
    .IDX_W    (IDX_W),
    .SEL_W    (SEL_W)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .evtValid  (evtValid),
    .evtAdd    (evtAdd),
    .evtIndex  (evtIndex),
    .busAddr   (busAddr),
    .busRd     (busRd),
    .busWr     (busWr),
    .strb      (strb),
    .evtByte   (evtByte),
    .evtBitMask(evtBitMask),
    .rdByte    (rdByte),
    .gpeSetMask(gpeSetMask)
  );

  cpu_hotadd_data #(
    .NUM_BYTES(NUM_BYTES),
    .CNT_W    (CNT_W),
    .SEL_W    (SEL_W)
  ) i_data (
    .clk       (clk),
    .rstN      (rstN),
    .bootCount (bootCount),
    .strb      (strb),
    .evtByte   (evtByte),
    .evtBitMask(evtBitMask),
    .rdByte    (rdByte),
    .rdData    (rdData)
  );

endmodule

// File: rtl/cpu_hotadd_bitmap_chk.sv
module cpu_hotadd_bitmap_chk #(
  parameter int MAX_CPUS = 256,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hAF00
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          evtValid,
  input logic                          evtAdd,
  input logic [$clog2(MAX_CPUS):0]     evtIndex,
  input logic [ADDR_W-1:0]             busAddr,
  input logic                          busRd,
  input logic                          busWr,
  input logic [7:0]                    rdData,
  input logic [7:0]                    gpeSetMask,
  input logic [MAX_CPUS-1:0]           statusBits
);

  localparam int IDX_W = $clog2(MAX_CPUS) + 1;
  localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(MAX_CPUS);

  logic validEvt;
  logic outsideWin;
  assign validEvt   = evtValid && (evtIndex < MAX_IDX);
  assign outsideWin = (busAddr < BASE_ADDR) ||
                      (busAddr >= BASE_ADDR + ADDR_W'(MAX_CPUS / 8));

  // R4
  add_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    validEvt && evtAdd |=> statusBits[$past(evtIndex[IDX_W-2:0])]);

  // R5
  remove_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    validEvt && !evtAdd |=> !statusBits[$past(evtIndex[IDX_W-2:0])]);

  // R6
  evt_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    validEvt |=> gpeSetMask == 8'h04);

  // R6
  evt_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !validEvt |=> gpeSetMask == 8'h00);

  // R7
  write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWr && !evtValid |=> $stable(statusBits));

  // R8
  bad_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtValid && !validEvt |=> $stable(statusBits) && gpeSetMask == 8'h00);

  // R3
  outside_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRd && !busWr && outsideWin |=> rdData == 8'h00);

endmodule

bind cpu_hotadd_bitmap cpu_hotadd_bitmap_chk #(
  .MAX_CPUS (MAX_CPUS),
  .ADDR_W   (ADDR_W),
  .BASE_ADDR(BASE_ADDR)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .evtValid  (evtValid),
  .evtAdd    (evtAdd),
  .evtIndex  (evtIndex),
  .busAddr   (busAddr),
  .busRd     (busRd),
  .busWr     (busWr),
  .rdData    (rdData),
  .gpeSetMask(gpeSetMask),
  .statusBits(i_data.statusBytes)
);

// File: tb/test_cpu_hotadd_bitmap.sv
`timescale 1ns/1ps
module test_cpu_hotadd_bitmap;

  localparam logic [15:0] BASE = 16'hAF00;
  localparam int NVEC = 11;
  // {kind[1:0], index[8:0], expected byte[7:0]}; kind 0 add, 1 remove, 2 bus write
  localparam logic [18:0] VEC [NVEC] = '{
    {2'd0, 9'd3,   8'hFF},
    {2'd1, 9'd0,   8'hFE},
    {2'd1, 9'd7,   8'h7E},
    {2'd0, 9'd12,  8'h17},
    {2'd1, 9'd9,   8'h15},
    {2'd0, 9'd255, 8'h80},
    {2'd0, 9'd248, 8'h81},
    {2'd1, 9'd255, 8'h01},
    {2'd2, 9'd9,   8'h15},
    {2'd0, 9'd128, 8'h01},
    {2'd0, 9'd0,   8'h7F}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [8:0]  bootCount = 9'd0;
  logic        evtValid = 1'b0;
  logic        evtAdd = 1'b0;
  logic [8:0]  evtIndex = 9'd0;
  logic [15:0] busAddr = 16'h0000;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  rdData;
  logic [7:0]  gpeSetMask;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cpu_hotadd_bitmap i_cpu_hotadd_bitmap (
    .clk(clk), .rstN(rstN), .bootCount(bootCount),
    .evtValid(evtValid), .evtAdd(evtAdd), .evtIndex(evtIndex),
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .rdData(rdData), .gpeSetMask(gpeSetMask)
  );

  function automatic logic [7:0] expFill(int count, int byteIdx);
    logic [7:0] v = 8'h00;
    for (int k = 0; k < 8; k++) v[k] = ((8 * byteIdx + k) < count);
    return v;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic doReset(int count);
    @(negedge clk);
    bootCount = 9'(count);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic sendEvt(logic add, logic [8:0] idx);
    @(negedge clk);
    evtValid = 1'b1; evtAdd = add; evtIndex = idx;
    @(negedge clk);
    evtValid = 1'b0;
  endtask

  task automatic busWrite(logic [15:0] addr);
    @(negedge clk);
    busWr = 1'b1; busAddr = addr;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(logic [15:0] addr, output logic [7:0] data);
    @(negedge clk);
    busRd = 1'b1; busAddr = addr;
    @(negedge clk);
    busRd = 1'b0;
    data = rdData;
  endtask

  task automatic fillCheck(int count);
    logic [7:0] d;
    doReset(count);
    for (int i = 0; i < 32; i++) begin
      busRead(BASE + 16'(i), d);
      check($sformatf("R1/R2 boot=%0d byte%0d", count, i), d, expFill(count, i));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    doReset(11);
    // R1: outputs after reset
    check("R1 rdData after reset", rdData, 8'h00);
    check("R1 gpeSetMask after reset", gpeSetMask, 8'h00);
    for (int i = 0; i < 32; i++) begin
      busRead(BASE + 16'(i), d);
      check($sformatf("R1/R2 boot=11 byte%0d", i), d, expFill(11, i));
    end

    // Table walk: R4 add, R5 remove, R6 pulse, R7 writes ignored
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] kind;
      logic [8:0] idx;
      kind = VEC[v][18:17];
      idx  = VEC[v][16:8];
      if (kind == 2'd2) begin
        busWrite(BASE + 16'(idx[7:3]));
        check($sformatf("R7 no pulse on write vec%0d", v), gpeSetMask, 8'h00);
      end else begin
        sendEvt(kind == 2'd0, idx);
        check($sformatf("R6 pulse vec%0d", v), gpeSetMask, 8'h04);
        @(negedge clk);
        check($sformatf("R6 pulse ends vec%0d", v), gpeSetMask, 8'h00);
      end
      busRead(BASE + 16'(idx[7:3]), d);
      check($sformatf("%s vec%0d", kind == 2'd0 ? "R4" : (kind == 2'd1 ? "R5" : "R7"), v),
            d, VEC[v][7:0]);
    end

    // R7: read and write strobes together start no read
    busRead(BASE + 16'd1, d);
    @(negedge clk);
    busRd = 1'b1; busWr = 1'b1; busAddr = BASE;
    @(negedge clk);
    busRd = 1'b0; busWr = 1'b0;
    check("R7 write blocks read", rdData, 8'h15);

    // R8: out-of-range indices alias onto byte 0 bits but must be ignored
    sendEvt(1'b1, 9'd263);
    check("R8 no pulse idx263", gpeSetMask, 8'h00);
    sendEvt(1'b0, 9'd256);
    check("R8 no pulse idx256", gpeSetMask, 8'h00);
    busRead(BASE, d);
    check("R8 byte0 unchanged", d, 8'h7F);

    // R3: just outside both window edges
    busRead(BASE + 16'd32, d);
    check("R3 read above window", d, 8'h00);
    busRead(BASE - 16'd1, d);
    check("R3 read below window", d, 8'h00);
    busRead(16'h0000, d);
    check("R3 read at zero", d, 8'h00);

    // R2: rdData holds between reads
    busRead(BASE, d);
    repeat (3) @(negedge clk);
    check("R2 rdData holds", rdData, 8'h7F);

    // R1: further boot counts
    fillCheck(0);
    fillCheck(8);
    fillCheck(13);
    fillCheck(256);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule